// File: doc/BRIEF.md
# Selectable-Ratio Third-Order Sinc Decimator

This block reduces the multi-bit output of a delta-sigma modulator to output words at a lower rate. It uses three cascaded integrators that run at the sample rate and three cascaded differentiators that run once per decimation period. The decimation ratio can be 32, 64, 128 or 256, chosen at run time. Each raw result is scaled to unity DC gain. The result is then limited to the resolution that the chosen ratio supports. It is delivered either as a 24-bit word with zeroed low bits or as a 16-bit word that is rounded to nearest.

A sample enters the filter only on a clock edge where `in_valid` is high. After the ratio's number of accepted samples, the block registers a new word and raises `out_ready` for one clock. The first two words after a reset or a configuration change come from partly filled delay lines. When `discard_en` is high those two words are withheld. A change on either select clears all filter state and starts settling again.

Top module: `sinc3_decimator`

## Requirements
- R1: `osr_sel` picks the ratio (0 = 32, 1 = 64, 2 = 128, 3 = 256). A word is produced on every ratio-th accepted sample. `out_ready` goes high in the cycle after the edge that accepted that sample and stays high for exactly one cycle.
- R2: Word k (k = 1, 2, ...) counts accepted samples from the last reset or clear. Its raw value y is the sum of h[j]·x[k·OSR−1−j]. The kernel h is three length-OSR unit boxcars convolved together. Samples before the reset or clear count as zero.
- R3: When `width24` = 1, y is multiplied by 2^(3·(8−log2 OSR)), divided by 16 with floor, and then has its 7, 4, 1 or 0 lowest bits cleared for ratio 32, 64, 128 or 256 (resolutions of 17, 20, 23 and 24 bits).
- R4: When `width24` = 0, the 24-bit value W from R3 becomes floor((W+128)/256). The result saturates at 32767, is sign-extended and appears on `out_data`.
- R5: A cycle with `in_valid` low is ignored: the sample is not used and does not count toward the ratio.
- R6: When `discard_en` is high, words 1 and 2 after a reset or clear give no `out_ready`, and `out_data` keeps its previous value. From word 3 on, every word is delivered. When `discard_en` is low, every word is delivered.
- R7: A change of `osr_sel` or `width24` clears all filter state and the word and sample counts. A sample offered in the cycle of the change is ignored. Reset treats ratio 32 / 16-bit as the current setting.
- R8: Reset drives `out_data` to 0 and `out_ready` low, and clears every filter register.
- R9: A constant input x gives, from word 3 on, the 24-bit word x·2^20 at every ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 4 | Signed modulator sample |
| osr_sel | input | 2 | Decimation ratio select |
| width24 | input | 1 | 1 = 24-bit words, 0 = rounded 16-bit words |
| discard_en | input | 1 | Withhold words from the unsettled filter |
| out_data | output | 24 | Signed output word |
| out_ready | output | 1 | One-cycle pulse when a new word is on out_data |

## Verification
The bench tries every ratio and both widths with four input patterns. A positive full-scale constant and a negative full-scale constant show that the DC gain is one and that zero padding is applied. A pseudo-random sequence, fed with gaps in the valid strobe, leaves nonzero low-order bits, so rounding and masking are exposed and any miscounted idle cycle shows up. A full-swing alternating sequence tests the wrap-around arithmetic at its limits. Further runs change a select part way through a word, and assert reset in the middle of a run. These show that the clear affects both the values and the settle suppression.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
    parameter int IN_W         = 4;
    parameter int ORDER        = 3;
    parameter int MIN_LOG_OSR  = 5;
    parameter int MAX_LOG_OSR  = 8;
    parameter int ACC_W        = IN_W + ORDER * MAX_LOG_OSR;
    parameter int OUT_W        = 24;
    parameter int NARROW_W     = 16;
    parameter int SETTLE_WORDS = 2;

    // log2 of the decimation ratio for a select value
    function automatic int log_osr(input logic [1:0] sel);
        return MIN_LOG_OSR + int'(sel);
    endfunction

    // number of zeroed low bits in the wide word for a select value
    function automatic int pad_bits(input logic [1:0] sel);
        case (sel)
            2'd0:    return 7;
            2'd1:    return 4;
            2'd2:    return 1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [OUT_W-1:0] pad_mask(input logic [1:0] sel);
        return OUT_W'((32'd1 << pad_bits(sel)) - 32'd1);
    endfunction
endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
    parameter int IN_W  = sinc3_pkg::IN_W,
    parameter int ACC_W = sinc3_pkg::ACC_W,
    parameter int ORDER = sinc3_pkg::ORDER
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    en,
    input  logic signed [IN_W-1:0]  x,
    output logic [ACC_W-1:0]        sum_next
);
    typedef struct packed {
        logic [ORDER-1:0][ACC_W-1:0] acc;
    } integ_state_t;

    integ_state_t s_d, s_q;
    logic [ACC_W-1:0] feed [ORDER+1];

    assign feed[0] = {{(ACC_W-IN_W){x[IN_W-1]}}, x};

    // each stage adds its own register to the freshly updated stage before it
    for (genvar g = 0; g < ORDER; g++) begin : g_stage
        assign feed[g+1] = s_q.acc[g] + feed[g];
    end

    assign sum_next = feed[ORDER];

    always_comb begin
        s_d = s_q;
        if (en) begin
            for (int k = 0; k < ORDER; k++) begin
                s_d.acc[k] = feed[k+1];
            end
        end
        if (clear) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_integ_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (s_q == '0));
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
    parameter int ACC_W = sinc3_pkg::ACC_W,
    parameter int ORDER = sinc3_pkg::ORDER
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    input  logic [ACC_W-1:0] din,
    output logic [ACC_W-1:0] dout
);
    typedef struct packed {
        logic [ORDER-1:0][ACC_W-1:0] dly;
    } comb_state_t;

    comb_state_t s_d, s_q;
    logic [ACC_W-1:0] diff [ORDER+1];

    assign diff[0] = din;

    for (genvar g = 0; g < ORDER; g++) begin : g_stage
        assign diff[g+1] = diff[g] - s_q.dly[g];
    end

    assign dout = diff[ORDER];

    always_comb begin
        s_d = s_q;
        if (en) begin
            for (int k = 0; k < ORDER; k++) begin
                s_d.dly[k] = diff[k];
            end
        end
        if (clear) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_comb_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (s_q == '0));
endmodule

// File: rtl/sinc3_fmt.sv
module sinc3_fmt #(
    parameter int ACC_W       = sinc3_pkg::ACC_W,
    parameter int OUT_W       = sinc3_pkg::OUT_W,
    parameter int NARROW_W    = sinc3_pkg::NARROW_W,
    parameter int MAX_LOG_OSR = sinc3_pkg::MAX_LOG_OSR,
    parameter int ORDER       = sinc3_pkg::ORDER
) (
    input  logic [ACC_W-1:0] raw,
    input  logic [1:0]       osr_sel,
    input  logic             wide,
    output logic [OUT_W-1:0] word
);
    localparam int DROP       = OUT_W - NARROW_W;
    localparam int ROUND_ONE  = 1 << (DROP - 1);

    int                  shift;
    logic [ACC_W-1:0]    aligned;
    logic [OUT_W-1:0]    top;
    logic [OUT_W-1:0]    masked;
    logic [OUT_W:0]      rsum;
    logic [NARROW_W:0]   q;
    logic [NARROW_W-1:0] narrow;

    always_comb begin
        shift   = ORDER * (MAX_LOG_OSR - sinc3_pkg::log_osr(osr_sel));
        aligned = raw << shift;
        top     = aligned[ACC_W-1 -: OUT_W];
        masked  = top & ~sinc3_pkg::pad_mask(osr_sel);
        rsum    = {masked[OUT_W-1], masked} + (OUT_W+1)'(ROUND_ONE);
        q       = rsum[OUT_W:DROP];
        if (!q[NARROW_W] && q[NARROW_W-1]) begin
            narrow = {1'b0, {(NARROW_W-1){1'b1}}};
        end else begin
            narrow = q[NARROW_W-1:0];
        end
        word = wide ? masked : {{DROP{narrow[NARROW_W-1]}}, narrow};
    end
endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator #(
    parameter int IN_W         = sinc3_pkg::IN_W,
    parameter int ORDER        = sinc3_pkg::ORDER,
    parameter int MAX_LOG_OSR  = sinc3_pkg::MAX_LOG_OSR,
    parameter int OUT_W        = sinc3_pkg::OUT_W,
    parameter int NARROW_W     = sinc3_pkg::NARROW_W,
    parameter int SETTLE_WORDS = sinc3_pkg::SETTLE_WORDS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_sample,
    input  logic [1:0]              osr_sel,
    input  logic                    width24,
    input  logic                    discard_en,
    output logic signed [OUT_W-1:0] out_data,
    output logic                    out_ready
);
    localparam int ACC_W = IN_W + ORDER * MAX_LOG_OSR;
    localparam int CNT_W = MAX_LOG_OSR;
    localparam int SET_W = $clog2(SETTLE_WORDS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SET_W-1:0] settle;
        logic [1:0]       osr;
        logic             wide;
        logic [OUT_W-1:0] data;
        logic             ready;
    } top_state_t;

    top_state_t s_d, s_q;

    logic             cfg_change;
    logic             accept;
    logic             decim;
    logic             settled;
    logic [CNT_W-1:0] osr_m1;
    logic [ACC_W-1:0] integ_out;
    logic [ACC_W-1:0] comb_out;
    logic [OUT_W-1:0] word;

    assign cfg_change = (osr_sel != s_q.osr) || (width24 != s_q.wide);
    assign accept     = in_valid && !cfg_change;
    assign osr_m1     = CNT_W'((32'd1 << sinc3_pkg::log_osr(s_q.osr)) - 32'd1);
    assign decim      = accept && (s_q.cnt == osr_m1);
    assign settled    = (s_q.settle == SET_W'(SETTLE_WORDS));

    sinc3_integ #(.IN_W(IN_W), .ACC_W(ACC_W), .ORDER(ORDER)) u_integ (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cfg_change),
        .en       (accept),
        .x        (in_sample),
        .sum_next (integ_out)
    );

    sinc3_comb #(.ACC_W(ACC_W), .ORDER(ORDER)) u_comb (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cfg_change),
        .en    (decim),
        .din   (integ_out),
        .dout  (comb_out)
    );

    sinc3_fmt #(
        .ACC_W(ACC_W), .OUT_W(OUT_W), .NARROW_W(NARROW_W),
        .MAX_LOG_OSR(MAX_LOG_OSR), .ORDER(ORDER)
    ) u_fmt (
        .raw     (comb_out),
        .osr_sel (s_q.osr),
        .wide    (s_q.wide),
        .word    (word)
    );

    always_comb begin
        s_d       = s_q;
        s_d.ready = 1'b0;
        if (cfg_change) begin
            s_d.osr    = osr_sel;
            s_d.wide   = width24;
            s_d.cnt    = '0;
            s_d.settle = '0;
        end else if (accept) begin
            s_d.cnt = decim ? '0 : s_q.cnt + 1'b1;
            if (decim) begin
                if (!settled) s_d.settle = s_q.settle + 1'b1;
                if (settled || !discard_en) begin
                    s_d.data  = word;
                    s_d.ready = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_data  = s_q.data;
    assign out_ready = s_q.ready;

    assert_ready_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |=> !out_ready);

    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= osr_m1);

    assert_ready_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |-> $past(in_valid));

    assert_settled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ready && $past(discard_en)) |-> ($past(s_q.settle) == SET_W'(SETTLE_WORDS)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_data != $past(out_data)) |-> out_ready);

    assert_pad_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ready && s_q.wide) |-> ((out_data & sinc3_pkg::pad_mask(s_q.osr)) == '0));

    assert_sign_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ready && !s_q.wide) |->
            (out_data[OUT_W-1:NARROW_W] == {(OUT_W-NARROW_W){out_data[NARROW_W-1]}}));
endmodule

// File: tb/sinc3_decimator_bench.sv
`timescale 1ns/1ps
module sinc3_decimator_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_sample = '0;
    logic [1:0]  osr_sel = '0;
    logic        width24 = 1'b0;
    logic        discard_en = 1'b0;
    logic [23:0] out_data;
    logic        out_ready;

    int n_chk  = 0;
    int n_fail = 0;
    int h    [0:767];
    int box2 [0:511];
    int hist [0:2047];
    longint last_data = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    sinc3_decimator u_sinc3_decimator (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .osr_sel(osr_sel), .width24(width24), .discard_en(discard_en),
        .out_data(out_data), .out_ready(out_ready)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pat(input int p, input int n);
        case (p)
            0:       return 7;
            1:       return -8;
            2:       return ((n * 13 + (n * n) % 29 + 3) % 16) - 8;
            default: return (n % 2 == 1) ? 7 : -8;
        endcase
    endfunction

    task automatic build_h(input int osr);
        for (int j = 0; j <= 2 * osr - 2; j++) box2[j] = (j < osr) ? j + 1 : 2 * osr - 1 - j;
        for (int j = 0; j <= 3 * osr - 3; j++) begin
            h[j] = 0;
            for (int a = 0; a < osr; a++) begin
                if (j - a >= 0 && j - a <= 2 * osr - 2) h[j] += box2[j - a];
            end
        end
    endtask

    // expected port value for word k, from R2, R3 and R4
    function automatic longint expect_word(input int sel, input bit wide, input int k);
        int     osr = 1 << (5 + sel);
        int     pad = (sel == 0) ? 7 : (sel == 1) ? 4 : (sel == 2) ? 1 : 0;
        longint y = 0;
        longint w;
        longint q;
        for (int j = 0; j <= 3 * osr - 3; j++) begin
            if (k * osr - 1 - j >= 0) y += longint'(h[j]) * longint'(hist[k * osr - 1 - j]);
        end
        w = (y * (longint'(1) << (3 * (3 - sel)))) >>> 4;
        w = (w >>> pad) <<< pad;
        if (wide) return w;
        q = (w + 128) >>> 8;
        if (q > 32767) q = 32767;
        return q;
    endfunction

    task automatic do_reset(input int sel, input bit wide, input bit disc);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        osr_sel = 2'(sel); width24 = wide; discard_en = disc;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        last_data = 0;
        repeat (2) @(negedge clk);
    endtask

    // feeds samples until nwords words are due; assumes a cleared filter, current time at a negedge
    task automatic run(input int sel, input bit wide, input bit disc, input int p,
                       input int nwords, input bit gaps);
        int osr = 1 << (5 + sel);
        int n = 0;
        int k = 0;
        build_h(osr);
        discard_en = disc;
        while (k < nwords) begin
            bit v = gaps ? ((cyc % 3) != 1) : 1'b1;
            int s = pat(p, n);
            in_valid  = v;
            in_sample = v ? 4'(s) : 4'(pat(3, cyc + 1) ^ 5);
            if (v) begin hist[n] = s; n++; end
            cyc++;
            @(negedge clk);
            if (v && (n % osr == 0)) begin
                bit     dlv;
                longint e;
                longint act;
                k++;
                dlv = !(disc && k <= 2);
                e   = expect_word(sel, wide, k);
                act = longint'($signed(out_data));
                if (dlv) begin
                    chk(out_ready == 1'b1, "R1 ready on word", longint'(out_ready), 1);
                    chk(act == e, wide ? "R2 R3 wide word" : "R2 R4 narrow word", act, e);
                    if (wide && p < 2 && k >= 3)
                        chk(act == longint'(pat(p, 0)) * 1048576, "R9 dc gain", act,
                            longint'(pat(p, 0)) * 1048576);
                    last_data = e;
                end else begin
                    chk(out_ready == 1'b0, "R6 unsettled withheld", longint'(out_ready), 0);
                    chk(act == last_data, "R6 data held", act, last_data);
                end
            end else begin
                chk(out_ready == 1'b0, v ? "R1 no ready mid-word" : "R5 idle cycle",
                    longint'(out_ready), 0);
            end
        end
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_ready == 1'b0, "R1 single-cycle ready", longint'(out_ready), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R8: reset state
        do_reset(0, 1'b0, 1'b0);
        chk(out_ready == 1'b0, "R8 reset ready", longint'(out_ready), 0);
        chk(out_data == 24'd0, "R8 reset data", longint'(out_data), 0);

        // sweep: all ratios, both widths, four patterns, discard alternating
        for (int sel = 0; sel < 4; sel++) begin
            for (int wd = 0; wd < 2; wd++) begin
                for (int p = 0; p < 4; p++) begin
                    bit disc = bit'(p % 2) ^ bit'(wd);
                    do_reset(sel, bit'(wd), disc);
                    run(sel, bit'(wd), disc, p, 4, p == 2);
                end
            end
        end

        // R7: ratio change part way through a word, sample in change cycle ignored
        do_reset(0, 1'b1, 1'b1);
        run(0, 1'b1, 1'b1, 2, 4, 1'b0);
        for (int i = 0; i < 10; i++) begin
            in_valid = 1'b1; in_sample = 4'(pat(3, i));
            @(negedge clk);
            chk(out_ready == 1'b0, "R7 partial word no ready", longint'(out_ready), 0);
        end
        osr_sel = 2'd1; in_valid = 1'b1; in_sample = 4'd7;
        @(negedge clk);
        chk(out_ready == 1'b0, "R7 change cycle", longint'(out_ready), 0);
        run(1, 1'b1, 1'b1, 2, 4, 1'b0);

        // R7: width-only change restarts settling as well
        for (int i = 0; i < 5; i++) begin
            in_valid = 1'b1; in_sample = 4'(pat(2, i));
            @(negedge clk);
        end
        width24 = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        run(1, 1'b0, 1'b1, 3, 4, 1'b1);

        // R8: reset in the middle of a word clears output
        for (int i = 0; i < 20; i++) begin
            in_valid = 1'b1; in_sample = 4'(pat(2, i));
            @(negedge clk);
        end
        rst_n = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        chk(out_ready == 1'b0, "R8 mid-run reset ready", longint'(out_ready), 0);
        chk(out_data == 24'd0, "R8 mid-run reset data", longint'(out_data), 0);
        rst_n = 1'b1;
        last_data = 0;
        repeat (2) @(negedge clk);
        run(1, 1'b0, 1'b0, 2, 3, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule